// File: doc/BRIEF.md
# Interrupt Router and Aggregator

This block takes a vector of active device interrupts and presents them to the rest of the chip in one of two ways, chosen by a static mode strap. In routed mode each interrupt is steered to one of four interrupt outputs through a 2-bit route field. The sixteen fields are spread over two 32-bit route registers. In legacy mode the route fields are ignored. Any active interrupt then sets one bit of an input register, and that bit is accumulated through a mask into a sticky status register that drives a single aggregated output.

Software reaches the block through a simple 32-bit register port. A write takes effect on the clock edge and a read returns data combinationally. The port holds two route registers, a sticky status register that is cleared by writing ones, a mask, a polarity register that is stored but has no effect, and a read-only input register. An offset that is not decoded reads as all ones.

Top module: `irq_route_agg`

## Requirements
- R1: After reset every implemented register reads zero, all four routed outputs are low and the aggregated output is low.
- R2: The route registers (offset 0x08 and 0x0C), the mask (0x54) and the polarity register (0x58) store all 32 written bits and read them back unchanged.
- R3: A read from any offset other than 0x08, 0x0C, 0x50, 0x54, 0x58 and 0x5C returns 0xFFFFFFFF. A write to such an offset changes no register and no output.
- R4: The input register (0x5C) is read-only. Bit 11 reads 1 one cycle after a clock edge where legacy mode was selected and at least one interrupt was active. In every other case bit 11 reads 0. All other bits always read 0.
- R5: Interrupt n, for n from 0 to 13, takes its output number from bits [27-2n:26-2n] of the route register at 0x0C.
- R6: Interrupt n, for n of 14 or 15, takes its output number from bits [23-2(n-14):22-2(n-14)] of the route register at 0x08.
- R7: In routed mode, routed output k is high in the cycle after a clock edge exactly when some interrupt whose route field equals k was active at that edge. The outputs are not latched, and they follow a change of route register one cycle after the write.
- R8: In legacy mode all routed outputs are low. At every edge the status register (0x50) ORs in (input register AND mask), and the aggregated output is high exactly when the status register is nonzero.
- R9: Writing the status register clears each bit written as 1 and leaves bits written as 0 alone. A bit that the same edge sets again through input AND mask stays set.
- R10: The contents of the polarity register have no effect on any output or on any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | Mode strap: 1 selects the aggregated sticky output, 0 selects routed outputs |
| irq_active | input | 16 | Active interrupts, bit n is interrupt n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| route_irq | output | 4 | Routed interrupt outputs, registered |
| agg_irq | output | 1 | Aggregated interrupt, high while status is nonzero |

## Verification
The assertions assume that the mode strap changes only between test phases and that reset is synchronous and held for at least one edge. They also assume that the register port issues at most one write per cycle. The stimulus holds legacy_mode constant for long phases and switches it only at phase boundaries. It drives every input on the falling edge, and it aims random register writes at both decoded and undecoded offsets. Interrupt patterns are kept sparse so that single-interrupt and multi-interrupt routing both occur often.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFS_ROUTE_HI = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_ROUTE_LO = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h50;
   localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h54;
   localparam logic [ADDR_W-1:0] OFS_POLAR    = 8'h58;
   localparam logic [ADDR_W-1:0] OFS_INPUT    = 8'h5C;

   localparam int AGG_BIT = 11;
   localparam logic [DATA_W-1:0] RD_MISS = '1;

   typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  word_t             wdata,
   input  word_t             stat_q,
   input  word_t             inp_q,
   output word_t             route_hi_q,
   output word_t             route_lo_q,
   output word_t             mask_q,
   output word_t             stat_clr,
   output word_t             rdata
);
   word_t polar_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_hi_q <= '0;
         route_lo_q <= '0;
         mask_q     <= '0;
         polar_q    <= '0;
      end else if (we) begin
         case (addr)
            OFS_ROUTE_HI: route_hi_q <= wdata;
            OFS_ROUTE_LO: route_lo_q <= wdata;
            OFS_MASK:     mask_q     <= wdata;
            OFS_POLAR:    polar_q    <= wdata;
            default: ;
         endcase
      end
   end

   assign stat_clr = (we && addr == OFS_STATUS) ? wdata : '0;

   always_comb begin
      case (addr)
         OFS_ROUTE_HI: rdata = route_hi_q;
         OFS_ROUTE_LO: rdata = route_lo_q;
         OFS_STATUS:   rdata = stat_q;
         OFS_MASK:     rdata = mask_q;
         OFS_POLAR:    rdata = polar_q;
         OFS_INPUT:    rdata = inp_q;
         default:      rdata = RD_MISS;
      endcase
   end
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int ROUTE_W = 2,
   parameter int SPLIT   = 14,
   parameter int LO_TOP  = 27,
   parameter int HI_TOP  = 23,
   localparam int NUM_OUT = 1 << ROUTE_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               legacy,
   input  logic [NUM_IRQ-1:0] active,
   input  word_t              route_hi_q,
   input  word_t              route_lo_q,
   output logic [NUM_OUT-1:0] route_irq
);
   logic [ROUTE_W-1:0] sel [NUM_IRQ];
   logic [NUM_OUT-1:0] hit;
   logic               unused_route_bits;

   if (LO_TOP - ROUTE_W * SPLIT + 1 < 0) begin : g_lo_fit
      $error("low route register cannot hold SPLIT fields");
   end
   if (HI_TOP - ROUTE_W * (NUM_IRQ - SPLIT) + 1 < 0) begin : g_hi_fit
      $error("high route register cannot hold remaining fields");
   end
   if (LO_TOP >= DATA_W || HI_TOP >= DATA_W) begin : g_top_fit
      $error("route field top beyond register width");
   end

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_field
      if (n < SPLIT) begin : g_lo
         localparam int LSB = LO_TOP - ROUTE_W * n - (ROUTE_W - 1);
         assign sel[n] = route_lo_q[LSB +: ROUTE_W];
      end else begin : g_hi
         localparam int LSB = HI_TOP - ROUTE_W * (n - SPLIT) - (ROUTE_W - 1);
         assign sel[n] = route_hi_q[LSB +: ROUTE_W];
      end
   end

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      logic [NUM_IRQ-1:0] match;
      always_comb begin
         for (int n = 0; n < NUM_IRQ; n++) begin
            match[n] = active[n] && (sel[n] == ROUTE_W'(k));
         end
      end
      assign hit[k] = |match;
   end

   assign unused_route_bits = ^{route_hi_q, route_lo_q};

   always_ff @(posedge clk) begin
      if (!rst_n)      route_irq <= '0;
      else if (legacy) route_irq <= '0;
      else             route_irq <= hit;
   end
endmodule

// File: rtl/irq_route_latch.sv
module irq_route_latch
   import irq_route_pkg::*;
#(
   parameter int NUM_IRQ = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               legacy,
   input  logic [NUM_IRQ-1:0] active,
   input  word_t              mask_q,
   input  word_t              stat_clr,
   output word_t              inp_q,
   output word_t              stat_q,
   output logic               agg_irq
);
   if (AGG_BIT >= DATA_W) begin : g_bit_fit
      $error("aggregate bit beyond register width");
   end

   word_t inp_next;

   always_comb begin
      inp_next          = '0;
      inp_next[AGG_BIT] = legacy && (|active);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inp_q  <= '0;
         stat_q <= '0;
      end else begin
         inp_q  <= inp_next;
         stat_q <= (stat_q & ~stat_clr) | (inp_q & mask_q);
      end
   end

   assign agg_irq = |stat_q;
endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
   import irq_route_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int ROUTE_W = 2,
   parameter int SPLIT   = 14,
   parameter int LO_TOP  = 27,
   parameter int HI_TOP  = 23,
   localparam int NUM_OUT = 1 << ROUTE_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               legacy_mode,
   input  logic [NUM_IRQ-1:0] irq_active,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_OUT-1:0] route_irq,
   output logic               agg_irq
);
   if (SPLIT < 0 || SPLIT > NUM_IRQ) begin : g_split_ok
      $error("SPLIT outside interrupt range");
   end

   word_t route_hi_w, route_lo_w, mask_w, clr_w, stat_w, inp_w;

   irq_route_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .stat_q     (stat_w),
      .inp_q      (inp_w),
      .route_hi_q (route_hi_w),
      .route_lo_q (route_lo_w),
      .mask_q     (mask_w),
      .stat_clr   (clr_w),
      .rdata      (reg_rdata)
   );

   irq_route_decode #(
      .NUM_IRQ (NUM_IRQ),
      .ROUTE_W (ROUTE_W),
      .SPLIT   (SPLIT),
      .LO_TOP  (LO_TOP),
      .HI_TOP  (HI_TOP)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .legacy     (legacy_mode),
      .active     (irq_active),
      .route_hi_q (route_hi_w),
      .route_lo_q (route_lo_w),
      .route_irq  (route_irq)
   );

   irq_route_latch #(
      .NUM_IRQ (NUM_IRQ)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .legacy   (legacy_mode),
      .active   (irq_active),
      .mask_q   (mask_w),
      .stat_clr (clr_w),
      .inp_q    (inp_w),
      .stat_q   (stat_w),
      .agg_irq  (agg_irq)
   );
endmodule

// File: rtl/irq_route_agg_chk.sv
module irq_route_agg_chk
   import irq_route_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int NUM_OUT = 4
)(
   input logic               clk,
   input logic               rst_n,
   input logic               legacy_mode,
   input logic [NUM_IRQ-1:0] irq_active,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_OUT-1:0] route_irq,
   input logic               agg_irq,
   input logic [DATA_W-1:0]  inp_w,
   input logic [DATA_W-1:0]  mask_w,
   input logic [DATA_W-1:0]  stat_w
);
   localparam logic [DATA_W-1:0] ONLY_AGG = DATA_W'(1) << AGG_BIT;

   // R8: legacy mode silences every routed output on the next cycle
   p_legacy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_mode |=> (route_irq == '0));

   // R8: a masked input bit always lands in status
   p_status_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(inp_w & mask_w)) |=> agg_irq);

   // R8: status is sticky unless a status write occurs
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (agg_irq && !(reg_we && reg_addr == OFS_STATUS)) |=> agg_irq);

   // R9: writing all ones with no masked input empties status
   p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_STATUS && (&reg_wdata) && ((inp_w & mask_w) == '0))
      |=> (stat_w == '0));

   // R4: only the aggregate bit of the input register can be set
   p_input_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inp_w & ~ONLY_AGG) == '0);

   // R7: a single active interrupt in routed mode drives exactly one output
   p_single_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_mode && $countones(irq_active) == 1) |=> ($countones(route_irq) == 1));

   // R7: routed mode with no pending input never latches anything
   p_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_mode && inp_w == '0 && !agg_irq) |=> !agg_irq);
endmodule

bind irq_route_agg irq_route_agg_chk #(
   .NUM_IRQ (NUM_IRQ),
   .NUM_OUT (NUM_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .legacy_mode (legacy_mode),
   .irq_active  (irq_active),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .route_irq   (route_irq),
   .agg_irq     (agg_irq),
   .inp_w       (inp_w),
   .mask_w      (mask_w),
   .stat_w      (stat_w)
);

// File: tb/irq_route_agg_tb.sv
module irq_route_agg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        legacy_mode = 1'b0;
   logic [15:0] irq_active = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  route_irq;
   logic        agg_irq;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_hi, m_lo, m_stat, m_mask, m_pol, m_inp;
   logic [3:0]  m_route;

   always #5 clk = ~clk;

   irq_route_agg u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .legacy_mode (legacy_mode),
      .irq_active  (irq_active),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .route_irq   (route_irq),
      .agg_irq     (agg_irq)
   );

   function automatic logic [1:0] field_of(int n, logic [31:0] hi, logic [31:0] lo);
      if (n < 14) return lo[27-2*n -: 2];
      return hi[23-2*(n-14) -: 2];
   endfunction

   function automatic logic [3:0] routes_of(logic [15:0] act, logic [31:0] hi, logic [31:0] lo);
      logic [3:0] r = '0;
      for (int n = 0; n < 16; n++)
         if (act[n]) r[field_of(n, hi, lo)] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] model_read(logic [7:0] a);
      case (a)
         8'h08: return m_hi;
         8'h0C: return m_lo;
         8'h50: return m_stat;
         8'h54: return m_mask;
         8'h58: return m_pol;
         8'h5C: return m_inp;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock: drive at falling edge, update model at rising edge, check outputs
   task automatic step(bit we, logic [7:0] a, logic [31:0] d,
                       logic [15:0] act, bit leg, string req);
      logic [31:0] n_stat, n_inp, clr;
      logic [3:0]  n_route;
      reg_we = we; reg_addr = a; reg_wdata = d;
      irq_active = act; legacy_mode = leg;
      @(posedge clk);
      clr     = (we && a == 8'h50) ? d : 32'h0;
      n_route = leg ? 4'h0 : routes_of(act, m_hi, m_lo);
      n_inp   = (leg && act != 0) ? 32'h0000_0800 : 32'h0;
      n_stat  = (m_stat & ~clr) | (m_inp & m_mask);
      if (we) begin
         case (a)
            8'h08: m_hi   = d;
            8'h0C: m_lo   = d;
            8'h54: m_mask = d;
            8'h58: m_pol  = d;
            default: ;
         endcase
      end
      m_route = n_route; m_inp = n_inp; m_stat = n_stat;
      @(negedge clk);
      reg_we = 1'b0;
      check({req, " routed outputs"}, {28'h0, route_irq}, {28'h0, m_route});
      check({req, " aggregated output"}, {31'h0, agg_irq}, {31'h0, (m_stat != 0)});
   endtask

   task automatic rd(logic [7:0] a, string req);
      reg_we = 1'b0; reg_addr = a;
      #1;
      check(req, reg_rdata, model_read(a));
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, string req);
      step(1'b1, a, d, irq_active, legacy_mode, req);
   endtask

   bit done = 1'b0;

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] addrs [7];
      addrs = '{8'h08, 8'h0C, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h20};
      m_hi = 0; m_lo = 0; m_stat = 0; m_mask = 0; m_pol = 0; m_inp = 0; m_route = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int i = 0; i < 6; i++) rd(addrs[i], "R1 reset read");
      check("R1 reset routed", {28'h0, route_irq}, 32'h0);
      check("R1 reset agg", {31'h0, agg_irq}, 32'h0);

      // R3: undecoded offsets read as ones, writes ignored
      rd(8'h00, "R3 miss read");
      rd(8'hFC, "R3 miss read");
      wr(8'h10, 32'h1234_5678, "R3");
      for (int i = 0; i < 6; i++) rd(addrs[i], "R3 no side effect");

      // R2: readback
      wr(8'h08, 32'hA5A5_0F0F, "R2"); rd(8'h08, "R2 readback hi");
      wr(8'h0C, 32'h5A5A_F0F0, "R2"); rd(8'h0C, "R2 readback lo");
      wr(8'h54, 32'hDEAD_BEEF, "R2"); rd(8'h54, "R2 readback mask");
      wr(8'h58, 32'h0BAD_CAFE, "R2"); rd(8'h58, "R2 readback polarity");

      // R5: each low-register interrupt alone, routed to a distinct output
      wr(8'h08, 32'h0, "R5"); wr(8'h54, 32'h0, "R5");
      for (int n = 0; n < 14; n++) begin
         logic [31:0] v = 32'h0;
         v[27-2*n -: 2] = 2'((n % 3) + 1);
         wr(8'h0C, v, "R5");
         step(1'b0, 8'h0, 0, 16'(1 << n), 1'b0, "R5");
         check("R5 field position", {28'h0, route_irq}, {28'h0, 4'(1 << ((n % 3) + 1))});
      end

      // R6: interrupts 14 and 15 through the high register
      wr(8'h0C, 32'h0, "R6");
      wr(8'h08, 32'h00C0_0000, "R6");
      step(1'b0, 8'h0, 0, 16'h4000, 1'b0, "R6");
      check("R6 irq14 to 3", {28'h0, route_irq}, 32'h8);
      wr(8'h08, 32'h0020_0000, "R6");
      step(1'b0, 8'h0, 0, 16'h8000, 1'b0, "R6");
      check("R6 irq15 to 2", {28'h0, route_irq}, 32'h4);

      // R7: not latched; route change follows next cycle
      step(1'b0, 8'h0, 0, 16'h0, 1'b0, "R7");
      check("R7 released", {28'h0, route_irq}, 32'h0);
      irq_active = 16'h8000;
      wr(8'h08, 32'h0030_0000, "R7");
      step(1'b0, 8'h0, 0, 16'h8000, 1'b0, "R7");
      check("R7 reroute", {28'h0, route_irq}, 32'h8);

      // R4 / R8: legacy latch
      wr(8'h54, 32'h0000_0800, "R8");
      step(1'b0, 8'h0, 0, 16'h0010, 1'b1, "R8");
      rd(8'h5C, "R4 input bit set");
      check("R4 input value", reg_rdata, 32'h0000_0800);
      wr(8'h5C, 32'hFFFF_FFFF, "R4"); rd(8'h5C, "R4 read-only");
      step(1'b0, 8'h0, 0, 16'h0, 1'b1, "R8");
      step(1'b0, 8'h0, 0, 16'h0, 1'b1, "R8");
      step(1'b0, 8'h0, 0, 16'h0, 1'b1, "R8");
      check("R8 sticky agg", {31'h0, agg_irq}, 32'h1);
      rd(8'h5C, "R4 input bit clear");

      // R9: write zero leaves, write one clears, reassert wins
      wr(8'h50, 32'h0000_0000, "R9"); rd(8'h50, "R9 zero write keeps");
      wr(8'h50, 32'h0000_0800, "R9"); rd(8'h50, "R9 cleared");
      check("R9 agg low", {31'h0, agg_irq}, 32'h0);
      step(1'b0, 8'h0, 0, 16'h0100, 1'b1, "R9");
      step(1'b0, 8'h0, 0, 16'h0100, 1'b1, "R9");
      step(1'b1, 8'h50, 32'hFFFF_FFFF, 16'h0100, 1'b1, "R9");
      check("R9 reassert wins", {31'h0, agg_irq}, 32'h1);

      // R10: polarity has no effect
      wr(8'h58, 32'hFFFF_FFFF, "R10");
      step(1'b0, 8'h0, 0, 16'h0100, 1'b1, "R10");
      step(1'b0, 8'h0, 0, 16'h0300, 1'b0, "R10");
      wr(8'h58, 32'h0, "R10");

      // random phases
      for (int ph = 0; ph < 8; ph++) begin
         bit leg = ph[0];
         for (int c = 0; c < 500; c++) begin
            bit we = ($urandom % 4) == 0;
            logic [7:0] a = ($urandom % 8 == 7) ? 8'($urandom) : addrs[$urandom % 7];
            logic [15:0] act = 16'($urandom & $urandom & $urandom);
            step(we, a, $urandom, act, leg, leg ? "R8 random" : "R7 random");
            rd(addrs[$urandom % 7], "R2 random read");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule